// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the feedback divider of a frequency synthesizer. It runs on the oscillator signal itself and produces one pulse for each complete divide cycle. That pulse train goes to the phase comparator at the reference rate, which is about 10 kHz for an oscillator near 200 to 210 MHz. The divider has three parts: a model of a dual-modulus prescaler that divides by 100 or 101, a swallow counter that chooses the modulus, and a main counter that marks the end of each cycle.

A three-digit BCD channel word v (hundreds, tens, units) sets the ratio. The counter chain starts from a preset of 3200 + v and counts up to a fixed terminal value of 24200. Each divide cycle is therefore 21000 − v oscillator clocks long, so a larger channel value gives a shorter cycle. Internally the main counter is preset to 209 − hundreds and the swallow counter to 100 − (tens·10 + units). Together these give the same cycle length.

A load strobe captures a new channel word into a pending register. The counters read that register only when the terminal count reloads them, so every divide cycle uses a single ratio from start to finish. A strobe on the terminal-count clock itself takes effect at the reload after that one. A word that contains a digit above 9 is refused: the last valid word stays in use and an error flag is raised.

Top module: `psd_divider`

## Requirements
- R1: The number of clocks from one `div_pulse` to the next equals 21000 − v, where v = 100·hundreds + 10·tens + units of the channel word that the counters hold.
- R2: `div_pulse` is high for exactly one clock per divide cycle, on the terminal-count clock, and low on the clock after it.
- R3: `mod_sel` (1 = divide by 101, 0 = divide by 100) is high for exactly 101·(100 − (10·tens + units)) clocks in each divide cycle, all at the start of the cycle.
- R4: A channel word loaded while a divide cycle is running does not change that cycle's length. It applies from the next cycle on.
- R5: A load whose hundreds, tens or units digit is above 9 sets `bcd_err` on the next clock and leaves the pending word unchanged, so later cycles keep the last valid ratio.
- R6: A load of three valid digits clears `bcd_err` on the next clock.
- R7: After a synchronous reset the channel word is 000, `div_pulse` and `bcd_err` are low, `mod_sel` is high, and the first pulse arrives 21000 clocks into the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Strobe that captures the channel digits |
| ch_hund | input | 4 | Hundreds BCD digit of the channel word |
| ch_tens | input | 4 | Tens BCD digit of the channel word |
| ch_unit | input | 4 | Units BCD digit of the channel word |
| div_pulse | output | 1 | One-clock pulse at the end of each divide cycle |
| mod_sel | output | 1 | Prescaler modulus in use: 1 for 101, 0 for 100 |
| bcd_err | output | 1 | Last load held a digit above 9 |

## Verification
The hardest behaviour to show from the ports is that a divide cycle never runs with a mixed ratio. The internal reload is not visible, so the only evidence is the clock count between two pulses. The stimulus therefore loads each new word a few dozen clocks after a pulse, well inside a running cycle. A scoreboard expects the old length for that cycle and the new length only for the cycle after it. The refused word is tested the same way: a whole cycle must pass with the earlier ratio still in use. The bench also counts the clocks during which `mod_sel` is high in each cycle, which gives the swallow count independently of the overall length.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // A BCD digit is legal only in the range 0..9.
  function automatic logic bcd_ok(input logic [3:0] d);
    return d <= 4'd9;
  endfunction

  // Number of prescaler periods run at the high modulus.
  function automatic int unsigned swallow_preset(input int unsigned pre_mod,
                                                 input logic [3:0] tens,
                                                 input logic [3:0] units);
    return pre_mod - (32'(tens) * 32'd10 + 32'(units));
  endfunction

  // Number of prescaler periods in a whole divide cycle.
  function automatic int unsigned main_preset(input int unsigned main_base,
                                              input logic [3:0] hund);
    return main_base - 32'(hund);
  endfunction

endpackage

// File: rtl/psd_chan_word.sv
module psd_chan_word
  import psd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [3:0] dig_h,
  input  logic [3:0] dig_t,
  input  logic [3:0] dig_u,
  output logic [3:0] word_h,
  output logic [3:0] word_t,
  output logic [3:0] word_u,
  output logic       bcd_err
);

  logic digits_ok;
  assign digits_ok = bcd_ok(dig_h) && bcd_ok(dig_t) && bcd_ok(dig_u);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_h  <= 4'd0;
      word_t  <= 4'd0;
      word_u  <= 4'd0;
      bcd_err <= 1'b0;
    end else if (load) begin
      if (digits_ok) begin
        word_h  <= dig_h;
        word_t  <= dig_t;
        word_u  <= dig_u;
        bcd_err <= 1'b0;
      end else begin
        bcd_err <= 1'b1;
      end
    end
  end

  // R5: a bad digit raises the flag on the next clock
  p_bad_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !digits_ok) |=> bcd_err);

  // R5: a refused word leaves the pending word untouched
  p_bad_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !digits_ok) |=> ($stable(word_h) && $stable(word_t) && $stable(word_u)));

  // R6: a good word clears the flag
  p_good_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (load && digits_ok) |=> !bcd_err);

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int PRE_MOD = 100,
  parameter int PW      = $clog2(PRE_MOD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_plus1,
  output logic pre_wrap
);

  localparam logic [PW-1:0] LAST_LO = PW'(PRE_MOD - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(PRE_MOD);

  logic [PW-1:0] phase;

  assign pre_wrap = sel_plus1 ? (phase == LAST_HI) : (phase == LAST_LO);

  always_ff @(posedge clk) begin
    if (rst)           phase <= '0;
    else if (pre_wrap) phase <= '0;
    else               phase <= phase + 1'b1;
  end

  // R3: the phase never passes the high modulus
  p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_HI);

  // R3: with the low modulus selected the phase stays below it
  p_low_range_r3: assert property (@(posedge clk) disable iff (rst)
    !sel_plus1 |-> phase <= LAST_LO);

  // R1: each wrap starts a fresh prescaler period
  p_wrap_restart_r1: assert property (@(posedge clk) disable iff (rst)
    pre_wrap |=> phase == '0);

endmodule

// File: rtl/psd_counters.sv
module psd_counters #(
  parameter int SW = 7,
  parameter int MW = 8,
  parameter logic [SW-1:0] SW_RST = '0,
  parameter logic [MW-1:0] MN_RST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_wrap,
  input  logic [SW-1:0] sw_init,
  input  logic [MW-1:0] mn_init,
  output logic          sel_plus1,
  output logic          term_hit
);

  logic [SW-1:0] sw_left;
  logic [MW-1:0] mn_left;

  assign sel_plus1 = (sw_left != '0);
  assign term_hit  = pre_wrap && (mn_left == MW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_left <= SW_RST;
      mn_left <= MN_RST;
    end else if (term_hit) begin
      sw_left <= sw_init;
      mn_left <= mn_init;
    end else if (pre_wrap) begin
      mn_left <= mn_left - 1'b1;
      if (sw_left != '0) sw_left <= sw_left - 1'b1;
    end
  end

  // R2: the terminal count lasts a single clock
  p_one_clock_r2: assert property (@(posedge clk) disable iff (rst)
    term_hit |=> !term_hit);

  // R3: the swallow count runs out before the main count does
  p_swallow_below_main_r3: assert property (@(posedge clk) disable iff (rst)
    MW'(sw_left) < mn_left);

  // R1: the main counter never reaches zero
  p_main_live_r1: assert property (@(posedge clk) disable iff (rst)
    mn_left != '0);

endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter int TERM_CNT  = 24200,
  parameter int CHAIN_OFS = 3200,
  parameter int PRE_MOD   = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [3:0] ch_hund,
  input  logic [3:0] ch_tens,
  input  logic [3:0] ch_unit,
  output logic       div_pulse,
  output logic       mod_sel,
  output logic       bcd_err
);

  localparam int SPAN      = TERM_CNT - CHAIN_OFS;
  localparam int MAIN_BASE = SPAN / PRE_MOD - 1;
  localparam int MW        = $clog2(MAIN_BASE + 1);
  localparam int SW        = $clog2(PRE_MOD + 1);
  localparam logic [SW-1:0] SW_RST = SW'(PRE_MOD);
  localparam logic [MW-1:0] MN_RST = MW'(MAIN_BASE);

  logic [3:0]    word_h, word_t, word_u;
  logic [SW-1:0] sw_init;
  logic [MW-1:0] mn_init;
  logic          pre_wrap;
  logic          sel_plus1;
  logic          term_hit;

  assign sw_init = SW'(swallow_preset(PRE_MOD, word_t, word_u));
  assign mn_init = MW'(main_preset(MAIN_BASE, word_h));

  psd_chan_word u_word (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .dig_h   (ch_hund),
    .dig_t   (ch_tens),
    .dig_u   (ch_unit),
    .word_h  (word_h),
    .word_t  (word_t),
    .word_u  (word_u),
    .bcd_err (bcd_err)
  );

  psd_prescaler #(.PRE_MOD(PRE_MOD), .PW(SW)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .sel_plus1 (sel_plus1),
    .pre_wrap  (pre_wrap)
  );

  psd_counters #(.SW(SW), .MW(MW), .SW_RST(SW_RST), .MN_RST(MN_RST)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .pre_wrap  (pre_wrap),
    .sw_init   (sw_init),
    .mn_init   (mn_init),
    .sel_plus1 (sel_plus1),
    .term_hit  (term_hit)
  );

  assign div_pulse = term_hit;
  assign mod_sel   = sel_plus1;

  // R7: leaving reset shows channel 000 state at the ports
  p_reset_state_r7: assert property (@(posedge clk)
    rst |=> (mod_sel && !div_pulse && !bcd_err));

  // R3: a pulse never falls while the high modulus is selected
  p_pulse_low_mod_r3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> !mod_sel);

endmodule

// File: tb/sim_psd_divider.sv
module sim_psd_divider;
  localparam int CLK_PERIOD = 10;
  localparam int N_CYCLES   = 7;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [3:0] ch_hund = 4'd0, ch_tens = 4'd0, ch_unit = 4'd0;
  logic       div_pulse, mod_sel, bcd_err;

  psd_divider u0 (
    .clk(clk), .rst(rst), .load(load),
    .ch_hund(ch_hund), .ch_tens(ch_tens), .ch_unit(ch_unit),
    .div_pulse(div_pulse), .mod_sel(mod_sel), .bcd_err(bcd_err)
  );

  typedef struct {
    int    ratio;
    int    swc;
    int    chan;
    string tag;
  } exp_t;

  exp_t expq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Expected cycle length and high-modulus clocks, from the requirements.
  task automatic push(input int v, input string tag);
    exp_t e;
    e.chan  = v;
    e.ratio = (24200 - 3200) - v;
    e.swc   = 101 * (100 - (v % 100));
    e.tag   = tag;
    expq.push_back(e);
  endtask

  task automatic load_word(input logic [3:0] h, input logic [3:0] t, input logic [3:0] u);
    @(negedge clk);
    ch_hund = h; ch_tens = t; ch_unit = u;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic load_int(input int v);
    load_word(4'(v / 100), 4'((v / 10) % 10), 4'(v % 10));
  endtask

  // Driver
  initial begin
    int v1, v2;
    push(0, "R7");
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R7 div_pulse", int'(div_pulse), 0);
    check(mod_sel == 1'b1, "R7 mod_sel", int'(mod_sel), 1);
    check(bcd_err == 1'b0, "R7 bcd_err", int'(bcd_err), 0);
    rst = 1'b0;

    repeat (50) @(negedge clk);
    load_int(500);
    check(bcd_err == 1'b0, "R6 valid load", int'(bcd_err), 0);
    push(500, "R4");

    wait_pulse();
    repeat (40) @(negedge clk);
    load_int(999);
    push(999, "R1");

    wait_pulse();
    repeat (25) @(negedge clk);
    load_word(4'd3, 4'hB, 4'd1);
    check(bcd_err == 1'b1, "R5 flag", int'(bcd_err), 1);
    push(999, "R5");

    wait_pulse();
    v1 = int'($urandom_range(999));
    repeat (10) @(negedge clk);
    load_int(v1);
    check(bcd_err == 1'b0, "R6 clear", int'(bcd_err), 0);
    push(v1, "R1");

    wait_pulse();
    v2 = int'($urandom_range(999));
    repeat (60) @(negedge clk);
    load_int(v2);
    push(v2, "R1");

    wait_pulse();
    push(v2, "R1");
  end

  // Monitor
  initial begin
    int cnt, swc;
    exp_t e;
    wait (!rst);
    cnt = 1;
    swc = 1;
    for (int k = 0; k < N_CYCLES; k++) begin
      forever begin
        @(negedge clk);
        cnt++;
        if (mod_sel) swc++;
        if (div_pulse) break;
      end
      if (expq.size() == 0) begin
        check(1'b0, "R1 queue empty", k, 0);
      end else begin
        e = expq.pop_front();
        check(cnt == e.ratio, {e.tag, " cycle length"}, cnt, e.ratio);
        check(swc == e.swc, "R3 high-modulus clocks", swc, e.swc);
      end
      @(negedge clk);
      check(div_pulse == 1'b0, "R2 pulse width", int'(div_pulse), 0);
      cnt = 1;
      swc = mod_sel ? 1 : 0;
    end
    done = 1'b1;
  end

  // Watchdog and summary
  initial begin
    fork
      wait (done);
      repeat (195000) @(posedge clk);
    join_any
    if (!done) check(1'b0, "R1 watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule